// File: doc/BRIEF.md
# SPI Slave with Downstream Chip-Select Forwarding

This block is a byte-oriented SPI slave with a small configuration register file and an eight-pin general-purpose output port. The host writes and reads registers with two-byte transactions. Any port pin can be turned into an auxiliary chip select. A one-byte hand-over command then pulls that pin low, so the shared SCLK and SDI lines reach a second SPI device. From that point the slave releases its own SDO and ignores all bus activity until the host raises the main chip select.

All SPI pins are sampled in a single system clock domain, and the slave acts on SCLK edges it finds in those samples. Data is taken in on the falling SCLK edge, most significant bit first. Read data is launched on the rising edge. A per-pin polarity bit chooses when the forwarded select goes low: right after the last falling edge of the command byte, or after the rising edge that follows it.

Top module: `spi_csfwd_slave`

## Requirements
- R1: After reset, gpio_out, gpio_oe and sdo_oe are all 0, and the level, polarity, output-enable and select-mode registers read back as 0.
- R2: Byte 0100_aaaa followed by a data byte writes register aaaa. Register 0 holds the pin levels, register 2 the polarity bits, register 8 the output enables (driven on gpio_oe) and register 9 the select-mode bits. Bit i belongs to pin i. A pin not in select mode drives its level bit on gpio_out.
- R3: Byte 1000_aaaa makes the next byte on SDO carry register aaaa, MSB first. Addresses other than 0, 2, 8 and 9 read as 0, and writes to them have no effect.
- R4: SDI is sampled on falling SCLK edges, MSB first. SDO changes only on rising SCLK edges, and the first bit of read data appears on the rising edge that follows the read command.
- R5: sdo_oe is 1 only while cs_n is low and the slave is decoding commands or moving register data. It is 0 whenever cs_n is high.
- R6: Byte 1100_0ppp, when pin ppp has both its output-enable and select-mode bits set, drives that pin low. If the pin's polarity bit is 1, the pin goes low right after the eighth falling edge. If it is 0, the pin goes low on the following rising edge.
- R7: While a pin is forwarded, sdo_oe is 0, and SCLK and SDI are ignored: no register changes.
- R8: cs_n high returns the forwarded pin high at once. It also clears the bit counter and the command state, and drops any partial byte.
- R9: A hand-over byte naming a pin that lacks the output-enable or the select-mode bit is ignored, and so is any other undefined command byte. The slave then leaves SDO released and every pin unchanged, and accepts no command until cs_n has been high.
- R10: A pin in select mode drives 1 whenever it is not the forwarded pin, whatever its level bit holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Main chip select, active low |
| sclk | input | 1 | SPI serial clock |
| sdi | input | 1 | SPI serial data into the slave |
| sdo | output | 1 | SPI serial data out of the slave |
| sdo_oe | output | 1 | Output enable for sdo; 0 means high impedance |
| gpio_out | output | 8 | Port pin levels |
| gpio_oe | output | 8 | Port pin output enables |

## Verification
The assertions watch several rules on every clock. SDO is released whenever cs_n is high and for the whole of a forwarded transfer. No more than one select-mode pin is ever low, and it is low exactly while forwarding. Select pins return high while cs_n is high, and the register file stays frozen during forwarding. Some behaviour only the bench scenarios can show. These are the exact edge at which each polarity setting drops the pin, the ordering of read data on SDO, and the rejection of hand-over bytes for pins that are not fully configured. They also include the discarding of a partial byte and the fact that writes sent during forwarding or after a rejected command never reach the registers. Both the scenarios and a behavioural model compared on every clock cover these.

// File: rtl/spi_csfwd_slave.sv
module spi_csfwd_slave #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            sclk,
  input  logic            sdi,
  output logic            sdo,
  output logic            sdo_oe,
  output logic [NPIN-1:0] gpio_out,
  output logic [NPIN-1:0] gpio_oe
);
  localparam int SEL_W = $clog2(NPIN);
  localparam logic [3:0] ADR_LVL = 4'd0;
  localparam logic [3:0] ADR_CP  = 4'd2;
  localparam logic [3:0] ADR_OE  = 4'd8;
  localparam logic [3:0] ADR_CSM = 4'd9;

  typedef enum logic [2:0] {ST_CMD, ST_WDAT, ST_RDAT, ST_ARM, ST_FWD, ST_HOLD} st_t;

  st_t             st;
  logic            sclk_q;
  logic [2:0]      cnt;
  logic [6:0]      sh_in;
  logic [7:0]      sh_out;
  logic [3:0]      addr;
  logic [SEL_W-1:0] sel;
  logic            sdo_q;
  logic [NPIN-1:0] reg_lvl, reg_cp, reg_oe, reg_csm;

  wire       fall      = !cs_n && sclk_q && !sclk;
  wire       rise      = !cs_n && !sclk_q && sclk;
  wire       shifting  = (st == ST_CMD) || (st == ST_WDAT) || (st == ST_RDAT);
  wire       byte_done = fall && shifting && (cnt == 3'd7);
  wire [7:0] rx        = {sh_in, sdi};
  wire [SEL_W-1:0] pin = rx[SEL_W-1:0];
  wire       fwd_on    = !cs_n && (st == ST_FWD);

  function automatic logic [7:0] rd_reg(input logic [3:0] a);
    logic [7:0] v;
    v = '0;
    case (a)
      ADR_LVL: v[NPIN-1:0] = reg_lvl;
      ADR_CP:  v[NPIN-1:0] = reg_cp;
      ADR_OE:  v[NPIN-1:0] = reg_oe;
      ADR_CSM: v[NPIN-1:0] = reg_csm;
      default: v = '0;
    endcase
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_CMD;
      sclk_q  <= 1'b1;
      cnt     <= '0;
      sh_in   <= '0;
      sh_out  <= '0;
      addr    <= '0;
      sel     <= '0;
      sdo_q   <= 1'b0;
      reg_lvl <= '0;
      reg_cp  <= '0;
      reg_oe  <= '0;
      reg_csm <= '0;
    end else begin
      sclk_q <= sclk;
      if (cs_n) begin
        st    <= ST_CMD;
        cnt   <= '0;
        sh_in <= '0;
        sdo_q <= 1'b0;
      end else begin
        if (fall && shifting) begin
          cnt   <= cnt + 3'd1;
          sh_in <= {sh_in[5:0], sdi};
        end
        if (rise && st == ST_RDAT) begin
          sdo_q  <= sh_out[7];
          sh_out <= {sh_out[6:0], 1'b0};
        end
        if (rise && st == ST_ARM)
          st <= ST_FWD;
        if (byte_done) begin
          case (st)
            ST_CMD: begin
              casez (rx)
                8'b0100_????: begin
                  addr <= rx[3:0];
                  st   <= ST_WDAT;
                end
                8'b1000_????: begin
                  sh_out <= rd_reg(rx[3:0]);
                  st     <= ST_RDAT;
                end
                8'b1100_0???: begin
                  if (reg_oe[pin] && reg_csm[pin]) begin
                    sel <= pin;
                    st  <= reg_cp[pin] ? ST_FWD : ST_ARM;
                  end else begin
                    st <= ST_HOLD;
                  end
                end
                default: st <= ST_HOLD;
              endcase
            end
            ST_WDAT: begin
              case (addr)
                ADR_LVL: reg_lvl <= rx[NPIN-1:0];
                ADR_CP:  reg_cp  <= rx[NPIN-1:0];
                ADR_OE:  reg_oe  <= rx[NPIN-1:0];
                ADR_CSM: reg_csm <= rx[NPIN-1:0];
                default: ;
              endcase
              st <= ST_CMD;
            end
            default: st <= ST_CMD;
          endcase
        end
      end
    end
  end

  wire [NPIN-1:0] low_mask = fwd_on ? (NPIN'(1) << sel) : '0;

  assign gpio_out = (reg_csm & ~low_mask) | (~reg_csm & reg_lvl);
  assign gpio_oe  = reg_oe;
  assign sdo      = sdo_q;
  assign sdo_oe   = !cs_n && shifting;
endmodule

module spi_csfwd_slave_chk #(
  parameter int NPIN = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_n,
  input logic            sdo_oe,
  input logic [NPIN-1:0] gpio_out,
  input logic [NPIN-1:0] csm,
  input logic            fwd,
  input logic [4*NPIN-1:0] regs
);
  // R5
  cs_high_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sdo_oe);
  // R7
  fwd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd |-> !sdo_oe);
  // R7
  fwd_regs_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd && $past(fwd)) |-> $stable(regs));
  // R6
  single_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(csm & ~gpio_out) <= 1);
  // R6
  fwd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd |-> ($countones(csm & ~gpio_out) == 1));
  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> ((gpio_out & csm) == csm));
endmodule

bind spi_csfwd_slave spi_csfwd_slave_chk #(.NPIN(NPIN)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo_oe(sdo_oe),
  .gpio_out(gpio_out), .csm(reg_csm), .fwd(fwd_on),
  .regs({reg_lvl, reg_cp, reg_oe, reg_csm})
);

// File: tb/spi_csfwd_slave_tb.sv
module spi_csfwd_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int H = 3;

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 1, sdi = 0;
  logic sdo, sdo_oe;
  logic [7:0] gpio_out, gpio_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  spi_csfwd_slave dut_i (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .gpio_out(gpio_out), .gpio_oe(gpio_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model: 0 cmd, 1 wdat, 2 rdat, 3 arm, 4 fwd, 5 hold
  int m_st = 0, m_cnt = 0, m_acc = 0, m_addr = 0, m_sel = 0, m_shq = 0;
  bit m_sdo = 0;
  logic [7:0] m_reg [16];

  initial for (int i = 0; i < 16; i++) m_reg[i] = 0;

  function automatic void m_cs_high();
    m_st = 0; m_cnt = 0; m_acc = 0; m_sdo = 0;
  endfunction

  function automatic void m_fall(bit b);
    if (m_st <= 2) begin
      m_acc = ((m_acc << 1) | b) & 255;
      m_cnt++;
      if (m_cnt == 8) begin
        m_cnt = 0;
        if (m_st == 0) begin
          if ((m_acc >> 4) == 4) begin m_addr = m_acc & 15; m_st = 1; end
          else if ((m_acc >> 4) == 8) begin
            int a = m_acc & 15;
            m_shq = (a == 0 || a == 2 || a == 8 || a == 9) ? m_reg[a] : 0;
            m_st = 2;
          end else if ((m_acc >> 3) == 5'b11000) begin
            int p = m_acc & 7;
            if (m_reg[8][p] && m_reg[9][p]) begin
              m_sel = p; m_st = m_reg[2][p] ? 4 : 3;
            end else m_st = 5;
          end else m_st = 5;
        end else if (m_st == 1) begin
          if (m_addr == 0 || m_addr == 2 || m_addr == 8 || m_addr == 9) m_reg[m_addr] = m_acc[7:0];
          m_st = 0;
        end else m_st = 0;
        m_acc = 0;
      end
    end
  endfunction

  function automatic void m_rise();
    if (m_st == 2) begin m_sdo = m_shq[7]; m_shq = (m_shq << 1) & 255; end
    else if (m_st == 3) m_st = 4;
  endfunction

  function automatic logic [7:0] m_gpio();
    logic [7:0] g;
    for (int i = 0; i < 8; i++)
      g[i] = m_reg[9][i] ? !(m_st == 4 && !cs_n && m_sel == i) : m_reg[0][i];
    return g;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      bit eoe;
      eoe = !cs_n && m_st <= 2;
      chk(gpio_out == m_gpio(), "R2 R6 R8 R10 model gpio_out", gpio_out, m_gpio());
      chk(gpio_oe == m_reg[8], "R2 model gpio_oe", gpio_oe, m_reg[8]);
      chk(sdo_oe == eoe, "R5 R7 R9 model sdo_oe", sdo_oe, eoe);
      if (eoe) chk(sdo == m_sdo, "R4 model sdo", sdo, m_sdo);
    end
  end

  task automatic wclk(int n); repeat (n) @(negedge clk); endtask
  task automatic cs_lo(); @(negedge clk); cs_n = 0; wclk(H); endtask
  task automatic cs_hi(); @(negedge clk); cs_n = 1; m_cs_high(); wclk(H); endtask
  task automatic fall_half(bit b); @(negedge clk); sclk = 0; sdi = b; m_fall(b); wclk(H); endtask
  task automatic rise_half(); @(negedge clk); sclk = 1; m_rise(); wclk(H); endtask

  task automatic xfer(logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      rx[i] = sdo;
      fall_half(tx[i]);
      rise_half();
    end
  endtask

  task automatic send(logic [7:0] tx);
    logic [7:0] d;
    xfer(tx, d);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] v);
    cs_lo(); send({4'b0100, a}); send(v); cs_hi();
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] v);
    cs_lo(); send({4'b1000, a}); xfer(8'h00, v); cs_hi();
  endtask

  // activation byte, stopping after its last falling edge
  task automatic act_to_last_fall(logic [2:0] p);
    logic [7:0] b;
    b = {5'b11000, p};
    for (int i = 7; i >= 1; i--) begin fall_half(b[i]); rise_half(); end
    fall_half(b[0]);
  endtask

  initial begin
    logic [7:0] v;
    wclk(4);
    rst_n = 1;
    wclk(2);
    // R1
    chk(gpio_out == 0, "R1 reset gpio_out", gpio_out, 0);
    chk(gpio_oe == 0, "R1 reset gpio_oe", gpio_oe, 0);
    chk(sdo_oe == 0, "R1 reset sdo_oe", sdo_oe, 0);
    rd(4'd8, v);
    chk(v == 0, "R1 reset output-enable register", v, 0);

    // R2 configuration
    cs_lo();
    chk(sdo_oe == 1, "R5 sdo_oe during command", sdo_oe, 1);
    send(8'h40); send(8'hA5); send(8'h48); send(8'h06);
    send(8'h49); send(8'h06); send(8'h42); send(8'h02);
    cs_hi();
    chk(sdo_oe == 0, "R5 sdo_oe with cs high", sdo_oe, 0);
    chk(gpio_oe == 8'h06, "R2 gpio_oe", gpio_oe, 8'h06);
    chk(gpio_out == 8'hA7, "R2 R10 gpio_out", gpio_out, 8'hA7);

    // R3 R4 reads
    rd(4'd0, v);  chk(v == 8'hA5, "R3 R4 read level register", v, 8'hA5);
    rd(4'd2, v);  chk(v == 8'h02, "R3 read polarity register", v, 8'h02);
    wr(4'd5, 8'hFF);
    rd(4'd5, v);  chk(v == 8'h00, "R3 unmapped address", v, 0);

    // R6 polarity 1 on pin 1
    cs_lo();
    act_to_last_fall(3'd1);
    chk(gpio_out == 8'hA5, "R6 pin1 low after last fall", gpio_out, 8'hA5);
    rise_half();
    // R7 traffic during forwarding
    send(8'h40); send(8'h00); send(8'h48); send(8'h00);
    chk(sdo_oe == 0, "R7 sdo released while forwarding", sdo_oe, 0);
    chk(gpio_out == 8'hA5, "R6 pin1 held low", gpio_out, 8'hA5);
    cs_hi();
    chk(gpio_out == 8'hA7, "R8 pin1 released", gpio_out, 8'hA7);
    rd(4'd0, v);  chk(v == 8'hA5, "R7 level register untouched", v, 8'hA5);
    chk(gpio_oe == 8'h06, "R7 output enables untouched", gpio_oe, 8'h06);

    // R6 polarity 0 on pin 2
    cs_lo();
    act_to_last_fall(3'd2);
    chk(gpio_out == 8'hA7, "R6 pin2 still high before rise", gpio_out, 8'hA7);
    rise_half();
    chk(gpio_out == 8'hA3, "R6 pin2 low after rise", gpio_out, 8'hA3);
    cs_hi();
    chk(gpio_out == 8'hA7, "R8 pin2 released", gpio_out, 8'hA7);

    // R8 partial byte discarded
    cs_lo();
    fall_half(0); rise_half(); fall_half(1); rise_half();
    fall_half(0); rise_half(); fall_half(0); rise_half();
    cs_hi();
    rd(4'd0, v);  chk(v == 8'hA5, "R8 partial byte aborted", v, 8'hA5);

    // R9 pin enabled but not in select mode
    wr(4'd8, 8'h0E);
    cs_lo(); send(8'hC3);
    chk(gpio_out == 8'hA7, "R9 pin3 unchanged", gpio_out, 8'hA7);
    chk(sdo_oe == 0, "R9 sdo released after rejected command", sdo_oe, 0);
    send(8'h40); send(8'h00);
    cs_hi();
    rd(4'd0, v);  chk(v == 8'hA5, "R9 write after rejection ignored", v, 8'hA5);
    // R9 pin without output enable, and undefined byte
    cs_lo(); send(8'hC0);
    chk(gpio_out == 8'hA7, "R9 pin0 unchanged", gpio_out, 8'hA7);
    cs_hi();
    cs_lo(); send(8'hC9);
    chk(sdo_oe == 0, "R9 undefined byte", sdo_oe, 0);
    send(8'h49); send(8'h00);
    cs_hi();
    rd(4'd9, v);  chk(v == 8'h06, "R9 select-mode register intact", v, 8'h06);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule